// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog whose timeout and expiry action come from one 8-bit control register. The timeout is counted in ticks of an external 16 Hz strobe (one tick is a sixteenth of a second). It is the product of a 5-bit multiplier and a power-of-four resolution. A software agent keeps the watchdog from firing by restarting it. Either a write of a new control value or a plain read of the current one is a restart.

When the countdown runs out, the block sets a sticky flag. It then takes one of two actions, chosen by the top bit of the control register. It either raises a one-cycle system-reset request and zeroes the control register, or it raises a one-cycle interrupt and leaves the control register as it was. There is no data stream, so every pin is a plain level or strobe with no handshake. Write and read strobes are single-cycle pulses. Each strobe cycle counts as one access.

Top module: `steer_wdog_top`

## Requirements
- R1: Control bits [6:2] are the multiplier M and bits [1:0] are the resolution code S. After a restart, the expiry action happens on the N-th consumed tick, where N = M × 4^S (for example, 0x0C gives 3 ticks and 0x7F gives 1984 ticks). Ticks are consumed only in cycles where `tick_16hz` is high.
- R2: A multiplier of zero, including the all-zero control value, leaves the watchdog disarmed. No expiry action ever follows it.
- R3: A write strobe stores `wr_data` in the control register and restarts the countdown from the new value. When a restart and the final tick fall in the same cycle, the restart wins and no expiry happens.
- R4: A read strobe restarts the countdown from the value currently held and does not change the control register.
- R5: Every restart clears flag bit 7 (`flags_q[7]`). Flag bits 6:0 always read zero.
- R6: On expiry, `flags_q[7]` becomes 1 in the same cycle as the expiry pulse. It stays at 1 until the next restart.
- R7: When control bit 7 is 1 at expiry, `rst_req` is high for exactly one cycle and the control register reads 0x00 from that cycle on.
- R8: When control bit 7 is 0 at expiry, `irq` is high for exactly one cycle and the control register keeps its value.
- R9: After an expiry the countdown stops. No further expiry happens, whatever ticks arrive, until the next restart.
- R10: After reset, the control register, the flags, `rst_req` and `irq` are all zero and the watchdog is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16hz | input | 1 | One-cycle strobe, sixteen per second |
| reg_wr | input | 1 | Control register write strobe (restart) |
| reg_rd | input | 1 | Control register read strobe (restart) |
| wr_data | input | 8 | Value written on `reg_wr` |
| ctrl_q | output | 8 | Current control register value |
| flags_q | output | 8 | Flags; bit 7 is the expiry flag |
| rst_req | output | 1 | One-cycle system-reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench goes after every resolution code, up to the largest timeout of 1984 ticks. A design that decoded the resolution or multiplier wrongly would fire on the wrong tick. The bench restarts the countdown mid-run with both a read and a write, and lines a write up with the final tick. A design that ignored reads, reloaded the wrong value or let expiry win that race would fire early. It drives long idle runs after an expiry and after a zero multiplier. A counter that wrapped around, or one that armed on a zero timeout, would produce events the scoreboard never expected. It also checks which action fired, the flag, and the control value after each expiry. This exposes swapped steering or a missing clear.

// File: rtl/steer_wdog_pkg.sv
package steer_wdog_pkg;
  localparam int CTRL_W  = 8;
  localparam int MULT_W  = 5;
  localparam int RES_W   = 2;
  localparam int MAX_EXP = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W   = MULT_W + MAX_EXP;

  // Ticks for a control value: multiplier shifted left by twice the resolution.
  function automatic logic [CNT_W-1:0] ticks_of(input logic [CTRL_W-1:0] c);
    logic [MULT_W-1:0] m;
    logic [RES_W-1:0]  s;
    m = c[RES_W +: MULT_W];
    s = c[RES_W-1:0];
    return {{(CNT_W-MULT_W){1'b0}}, m} << {s, 1'b0};
  endfunction
endpackage

// File: rtl/steer_wdog_cfg.sv
module steer_wdog_cfg
  import steer_wdog_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr_en,
  output logic [W-1:0] ctrl,
  output logic [W-1:0] load_val,
  output logic         restart
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl <= '0;
    else if (wr_en)  ctrl <= wr_data;
    else if (clr_en) ctrl <= '0;
  end

  assign restart  = wr_en | rd_en;
  assign load_val = wr_en ? wr_data : ctrl;

  AST_READ_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !clr_en) |=> (ctrl == $past(ctrl))); // R4
endmodule

// File: rtl/steer_wdog_cnt.sv
module steer_wdog_cnt #(
  parameter int CW = steer_wdog_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] load_ticks,
  input  logic          tick,
  output logic          expire
);
  logic [CW-1:0] remain;
  logic          armed;
  localparam logic [CW-1:0] ONE = CW'(1);

  assign expire = armed & tick & (remain == ONE) & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      armed  <= 1'b0;
    end else if (restart) begin
      remain <= load_ticks;
      armed  <= (load_ticks != '0);
    end else if (armed && tick) begin
      if (remain == ONE) begin
        remain <= '0;
        armed  <= 1'b0;
      end else begin
        remain <= remain - ONE;
      end
    end
  end

  AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (remain != '0)); // R9
  AST_STOP_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed); // R9
  AST_ZERO_NOT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && load_ticks == '0) |=> !armed); // R2
endmodule

// File: rtl/steer_wdog_fire.sv
module steer_wdog_fire (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  input  logic restart,
  output logic flag,
  output logic rst_req,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= expire & steer;
      irq     <= expire & ~steer;
      if (restart)     flag <= 1'b0;
      else if (expire) flag <= 1'b1;
    end
  end

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq)); // R7
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R7
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_FLAG_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> flag); // R6
endmodule

// File: rtl/steer_wdog_top.sv
module steer_wdog_top
  import steer_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16hz,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] flags_q,
  output logic              rst_req,
  output logic              irq
);
  logic [CTRL_W-1:0] load_val;
  logic              restart;
  logic              expire;
  logic              steer;
  logic              wd_flag;

  assign steer = ctrl_q[CTRL_W-1];

  steer_wdog_cfg #(.W(CTRL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .wr_data(wr_data), .clr_en(expire & steer),
    .ctrl(ctrl_q), .load_val(load_val), .restart(restart)
  );

  steer_wdog_cnt #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .load_ticks(ticks_of(load_val)), .tick(tick_16hz), .expire(expire)
  );

  steer_wdog_fire u_fire (
    .clk(clk), .rst_n(rst_n), .expire(expire), .steer(steer),
    .restart(restart), .flag(wd_flag), .rst_req(rst_req), .irq(irq)
  );

  assign flags_q = {wd_flag, {(CTRL_W-1){1'b0}}};

  AST_CTRL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (ctrl_q == '0)); // R7
  AST_RESTART_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> !flags_q[CTRL_W-1]); // R5
  AST_RESTART_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> !(rst_req || irq)); // R3
endmodule

// File: tb/steer_wdog_top_tb_top.sv
module steer_wdog_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16hz = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctrl_q, flags_q;
  logic       rst_req, irq;

  int checks = 0;
  int errors = 0;
  int ticks_seen = 0;
  bit done = 1'b0;
  int exp_q[$];   // encoded: kind*100000 + ticks, kind 1 = reset, 0 = irq

  always #4 clk = ~clk;

  steer_wdog_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .wr_data(wr_data), .ctrl_q(ctrl_q), .flags_q(flags_q),
    .rst_req(rst_req), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_event(input bit is_rst, input int n);
    exp_q.push_back(is_rst * 100000 + n);
  endtask

  task automatic do_write(input logic [7:0] v);
    @(posedge clk); #1;
    reg_wr = 1'b1; wr_data = v;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic do_read();
    @(posedge clk); #1;
    reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick_16hz = 1'b1;
      @(posedge clk); #1;
      tick_16hz = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
    end
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  // Monitor: outputs at negedge reflect the preceding edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req || irq) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected event rst=%0d irq=%0d after %0d ticks, expected none",
                   rst_req, irq, ticks_seen);
        end else begin
          int e;
          e = exp_q.pop_front();
          if ((rst_req ? 100000 : 0) + ticks_seen != e || (rst_req && irq)) begin
            errors++;
            $display("FAIL R1 event actual kind=%0d ticks=%0d expected kind=%0d ticks=%0d",
                     rst_req, ticks_seen, e / 100000, e % 100000);
          end
        end
      end
      if (reg_wr || reg_rd) ticks_seen = 0;
      else if (tick_16hz) ticks_seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ctrl", ctrl_q, 8'h00);
    chk("R10 flags", flags_q, 8'h00);
    chk("R10 outs", {rst_req, irq}, 0);
    run_ticks(20, 0);   // disarmed after reset: no event expected

    // R1 R8: 0x0C -> mult 3, res 0 -> 3 ticks, interrupt
    do_write(8'h0C);
    expect_event(0, 3);
    run_ticks(3, 0);
    @(negedge clk);
    chk("R6 flag set", flags_q, 8'h80);
    chk("R8 ctrl kept", ctrl_q, 8'h0C);
    // R9 no further events
    run_ticks(30, 1);
    chk("R6 flag sticky", flags_q, 8'h80);

    // R4 R5 read restarts with held value and clears flag
    do_read();
    @(negedge clk);
    chk("R5 flag cleared by read", flags_q, 8'h00);
    chk("R4 ctrl unchanged by read", ctrl_q, 8'h0C);
    expect_event(0, 3);
    run_ticks(3, 2);

    // R7: 0x89 steer, mult 2, res 1 -> 8 ticks, reset request
    do_write(8'h89);
    @(negedge clk);
    chk("R5 flag cleared by write", flags_q, 8'h00);
    expect_event(1, 8);
    run_ticks(8, 0);
    @(negedge clk);
    chk("R7 ctrl cleared", ctrl_q, 8'h00);
    chk("R6 flag after reset req", flags_q, 8'h80);
    run_ticks(20, 0);

    // R1 other resolutions
    do_write(8'h06); expect_event(0, 16);   run_ticks(16, 1);
    do_write(8'h07); expect_event(0, 64);   run_ticks(64, 0);
    do_write(8'hFF); expect_event(1, 1984); run_ticks(1984, 0);
    @(negedge clk);
    chk("R7 ctrl cleared max", ctrl_q, 8'h00);

    // R2 zero multiplier disables
    do_write(8'h00); run_ticks(100, 0);
    do_write(8'h03); run_ticks(100, 0);
    @(negedge clk);
    chk("R2 flag stays clear", flags_q, 8'h00);

    // R4 mid-run read restart
    do_write(8'h14);                 // 5 ticks
    run_ticks(3, 0);
    do_read();
    expect_event(0, 5);
    run_ticks(5, 0);

    // R3 mid-run write restart with new value
    do_write(8'h14);
    run_ticks(3, 0);
    do_write(8'h08);                 // 2 ticks
    expect_event(0, 2);
    run_ticks(2, 0);

    // R3 restart wins over the final tick
    do_write(8'h08);
    run_ticks(1, 0);
    @(posedge clk); #1;
    tick_16hz = 1'b1; reg_wr = 1'b1; wr_data = 8'h0C;
    @(posedge clk); #1;
    tick_16hz = 1'b0; reg_wr = 1'b0;
    @(negedge clk);
    chk("R3 no fire on collision", {rst_req, irq}, 0);
    chk("R3 ctrl written", ctrl_q, 8'h0C);
    expect_event(0, 3);
    run_ticks(3, 0);
    run_ticks(10, 0);

    chk("R1 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule